// File: doc/BRIEF.md
# Register Scoreboard with Bypass-Point Selection

This block keeps, for every architectural register of a single-issue, in-order pipeline, a record of the youngest instruction still in flight that will write it. The pipeline has three execution pipes: a one-stage ALU, a two-stage memory pipe and a four-stage multiplier. All three feed a shared write-back stage. For each register the record holds three things: whether a write is pending, which pipe produces the value, and a one-hot position vector. A bit is loaded into the vector at issue and moves one stage further each clock.

Two source register numbers are looked up every cycle. For each one the block says where the operand comes from: the register file, or a bypass point named by pipe and stage. If the value does not exist anywhere yet, it reports a stall instead. The stage at which each pipe first holds its result comes from a fixed per-pipe table. It is not stored in the entries. Issue logic uses the stall outputs to hold the consumer, and the bypass multiplexers use the pipe and stage outputs as their select.

Each entry is a two-state machine. ENT_IDLE means no write is pending. ENT_FLIGHT means a producer is in flight. The transitions are:
- ISSUE: ENT_IDLE to ENT_FLIGHT.
- REISSUE: ENT_FLIGHT to ENT_FLIGHT. A new producer for the same register replaces the old one.
- ADVANCE: ENT_FLIGHT to ENT_FLIGHT. The position bit moves one stage.
- RETIRE: ENT_FLIGHT to ENT_IDLE. The position bit leaves the write-back stage.
- FLUSH: any state to ENT_IDLE.

Top module: `sb_bypass_tracker`

## Requirements
- R1: While reset is low, and after it is released, every source lookup reports select 0 (register file), with pipe 0 and stage 0. Reset is asynchronous and active low.
- R2: Register 0 is never tracked. A lookup of register 0 always reports select 0, even after an issue to destination 0.
- R3: A source whose register has no pending write reports select 0. This includes the cycle in which its producer is being issued.
- R4: Pipe codes are ALU=0, MEM=1, MUL=2. Stage 0 is the first execute stage and stage d is write-back, where d is the pipe depth (1, 2 or 4). An ALU producer issued in cycle t is reported as select 1 (bypass) with pipe 0, stage 0 in cycle t+1. It is reported with stage 1 in cycle t+2, and as select 0 in cycle t+3.
- R5: A memory producer issued in cycle t is reported as select 2 (stall) in cycle t+1. It is then reported as a bypass from pipe 1, stage 1 in t+2 and stage 2 in t+3, and as the register file in t+4.
- R6: A multiply producer issued in cycle t is reported as a stall in cycles t+1 to t+3. It is then reported as a bypass from pipe 2, stage 3 in t+4 and stage 4 in t+5, and as the register file in t+6. A stall reports pipe 0 and stage 0, and drives the stall bit high.
- R7: An issue to a register that already has a write in flight replaces the entry. From then on, lookups follow only the newest producer's pipe and position.
- R8: A flush clears every entry in one cycle, so all lookups report the register file in the next cycle. A flush takes priority over an issue made in the same cycle.
- R9: The two source lookups are independent. Both may name the same register and then report identical answers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Clear all in-flight writes |
| iss_valid_i | input | 1 | An instruction issues this cycle |
| iss_unit_i | input | 2 | Pipe of the issuing instruction (0 ALU, 1 MEM, 2 MUL) |
| iss_rd_i | input | 5 | Destination register of the issuing instruction |
| rs1_i | input | 5 | First source register number |
| rs2_i | input | 5 | Second source register number |
| rs1_sel_o | output | 2 | First source: 0 register file, 1 bypass, 2 stall |
| rs1_unit_o | output | 2 | First source bypass pipe |
| rs1_stage_o | output | 3 | First source bypass stage |
| rs1_stall_o | output | 1 | First source not yet available |
| rs2_sel_o | output | 2 | Second source: 0 register file, 1 bypass, 2 stall |
| rs2_unit_o | output | 2 | Second source bypass pipe |
| rs2_stage_o | output | 3 | Second source bypass stage |
| rs2_stall_o | output | 1 | Second source not yet available |

## Verification
The bench walks each pipe's producer through every stage. It checks the exact cycle in which a stall becomes a bypass, and the cycle in which the bypass ends in a register-file read. Getting the availability table wrong by one would show up as an early multiply bypass, which reads garbage, or as an extra stall.

The bench also re-issues to a register while an older producer is still in flight. A design that kept the older producer would report a multiply stall or a bypass from the wrong pipe.

Further cases are a flush that coincides with an issue, and a write to register 0. A design that gave the issue priority would leave a stale pending entry. A design that tracked register 0 would stall on a hardwired zero.

// File: rtl/sb_pkg.sv
package sb_pkg;

    localparam int ALU_DEPTH = 1;
    localparam int MEM_DEPTH = 2;
    localparam int MUL_DEPTH = 4;
    localparam int VEC_W     = MUL_DEPTH + 1;
    localparam int STAGE_W   = $clog2(VEC_W);

    typedef enum logic [1:0] {
        FU_ALU = 2'd0,
        FU_MEM = 2'd1,
        FU_MUL = 2'd2
    } fu_e;

    typedef enum logic [1:0] {
        SEL_RF    = 2'd0,
        SEL_BYP   = 2'd1,
        SEL_STALL = 2'd2
    } sel_e;

    typedef enum logic {
        ENT_IDLE   = 1'b0,
        ENT_FLIGHT = 1'b1
    } ent_state_e;

    // Vector position of the write-back stage for a pipe.
    function automatic logic [STAGE_W-1:0] fu_wb_pos(input fu_e fu);
        logic [STAGE_W-1:0] p;
        unique case (fu)
            FU_ALU:  p = STAGE_W'(ALU_DEPTH);
            FU_MEM:  p = STAGE_W'(MEM_DEPTH);
            default: p = STAGE_W'(MUL_DEPTH);
        endcase
        return p;
    endfunction

    // First vector position at which a pipe holds its result.
    function automatic logic [STAGE_W-1:0] fu_ready_pos(input fu_e fu);
        return fu_wb_pos(fu) - STAGE_W'(1);
    endfunction

endpackage

// File: rtl/sb_entry.sv
module sb_entry
    import sb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             issue_hit,
    input  fu_e              issue_unit,
    output logic             pending,
    output fu_e              unit_tag,
    output logic [VEC_W-1:0] pos_vec
);

    ent_state_e       st_q, st_d;
    fu_e              unit_q, unit_d;
    logic [VEC_W-1:0] vec_q, vec_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ENT_IDLE;
            unit_q <= FU_ALU;
            vec_q  <= '0;
        end else begin
            st_q   <= st_d;
            unit_q <= unit_d;
            vec_q  <= vec_d;
        end
    end

    // Next state and entry contents
    always_comb begin
        st_d   = st_q;
        unit_d = unit_q;
        vec_d  = vec_q;
        unique case (st_q)
            ENT_IDLE: begin
                if (issue_hit) begin
                    st_d   = ENT_FLIGHT;
                    unit_d = issue_unit;
                    vec_d  = VEC_W'(1);
                end
            end
            ENT_FLIGHT: begin
                if (issue_hit) begin
                    unit_d = issue_unit;
                    vec_d  = VEC_W'(1);
                end else if (vec_q[fu_wb_pos(unit_q)]) begin
                    st_d  = ENT_IDLE;
                    vec_d = '0;
                end else begin
                    vec_d = vec_q << 1;
                end
            end
            default: begin
                st_d  = ENT_IDLE;
                vec_d = '0;
            end
        endcase
        if (flush) begin
            st_d  = ENT_IDLE;
            vec_d = '0;
        end
    end

    assign pending  = (st_q == ENT_FLIGHT);
    assign unit_tag = unit_q;
    assign pos_vec  = vec_q;

    p_vec_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pending |-> $onehot(pos_vec));

    p_idle_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !pending |-> (pos_vec == '0));

    p_retire_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && pos_vec[fu_wb_pos(unit_tag)] && !issue_hit && !flush) |=> !pending);

    p_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_hit && !flush) |=> (pending && pos_vec == VEC_W'(1) && unit_tag == $past(issue_unit)));

    p_flush_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !pending);

endmodule

// File: rtl/sb_src_lookup.sv
module sb_src_lookup
    import sb_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               is_zero,
    input  logic               pending,
    input  fu_e                unit_tag,
    input  logic [VEC_W-1:0]   pos_vec,
    output sel_e               sel,
    output fu_e                byp_unit,
    output logic [STAGE_W-1:0] byp_stage,
    output logic               stall
);

    logic [STAGE_W-1:0] pos;
    logic               live;

    always_comb begin
        pos = '0;
        for (int i = 0; i < VEC_W; i++) begin
            if (pos_vec[i]) pos = STAGE_W'(i);
        end
    end

    assign live = pending && !is_zero;

    always_comb begin
        sel       = SEL_RF;
        byp_unit  = FU_ALU;
        byp_stage = '0;
        stall     = 1'b0;
        if (live) begin
            if (pos < fu_ready_pos(unit_tag)) begin
                sel   = SEL_STALL;
                stall = 1'b1;
            end else begin
                sel       = SEL_BYP;
                byp_unit  = unit_tag;
                byp_stage = pos;
            end
        end
    end

    p_alu_no_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && unit_tag == FU_ALU) |-> !stall);

    p_mul_early_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !is_zero && unit_tag == FU_MUL && (pos_vec[0] || pos_vec[1] || pos_vec[2])) |-> stall);

    p_idle_rf_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !pending |-> (sel == SEL_RF && !stall));

endmodule

// File: rtl/sb_bypass_tracker.sv
module sb_bypass_tracker
    import sb_pkg::*;
#(
    parameter int NUM_REGS = 32,
    parameter int NUM_SRC  = 2,
    localparam int REG_W   = $clog2(NUM_REGS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush_i,
    input  logic               iss_valid_i,
    input  logic [1:0]         iss_unit_i,
    input  logic [REG_W-1:0]   iss_rd_i,
    input  logic [REG_W-1:0]   rs1_i,
    input  logic [REG_W-1:0]   rs2_i,
    output logic [1:0]         rs1_sel_o,
    output logic [1:0]         rs1_unit_o,
    output logic [STAGE_W-1:0] rs1_stage_o,
    output logic               rs1_stall_o,
    output logic [1:0]         rs2_sel_o,
    output logic [1:0]         rs2_unit_o,
    output logic [STAGE_W-1:0] rs2_stage_o,
    output logic               rs2_stall_o
);

    logic             pend_q [NUM_REGS];
    fu_e              tag_q  [NUM_REGS];
    logic [VEC_W-1:0] vec_q  [NUM_REGS];
    fu_e              iss_unit;

    assign iss_unit = fu_e'(iss_unit_i);

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_ent
        if (g == 0) begin : g_zero
            assign pend_q[g] = 1'b0;
            assign tag_q[g]  = FU_ALU;
            assign vec_q[g]  = '0;
        end else begin : g_trk
            sb_entry u_ent (
                .clk        (clk),
                .rst_n      (rst_n),
                .flush      (flush_i),
                .issue_hit  (iss_valid_i && (iss_rd_i == REG_W'(g))),
                .issue_unit (iss_unit),
                .pending    (pend_q[g]),
                .unit_tag   (tag_q[g]),
                .pos_vec    (vec_q[g])
            );
        end
    end

    logic [REG_W-1:0]   rs_idx  [NUM_SRC];
    sel_e               sel_w   [NUM_SRC];
    fu_e                unit_w  [NUM_SRC];
    logic [STAGE_W-1:0] stage_w [NUM_SRC];
    logic               stall_w [NUM_SRC];

    assign rs_idx[0] = rs1_i;
    assign rs_idx[1] = rs2_i;

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        sb_src_lookup u_lk (
            .clk       (clk),
            .rst_n     (rst_n),
            .is_zero   (rs_idx[s] == '0),
            .pending   (pend_q[rs_idx[s]]),
            .unit_tag  (tag_q[rs_idx[s]]),
            .pos_vec   (vec_q[rs_idx[s]]),
            .sel       (sel_w[s]),
            .byp_unit  (unit_w[s]),
            .byp_stage (stage_w[s]),
            .stall     (stall_w[s])
        );
    end

    assign rs1_sel_o   = sel_w[0];
    assign rs1_unit_o  = unit_w[0];
    assign rs1_stage_o = stage_w[0];
    assign rs1_stall_o = stall_w[0];
    assign rs2_sel_o   = sel_w[1];
    assign rs2_unit_o  = unit_w[1];
    assign rs2_stage_o = stage_w[1];
    assign rs2_stall_o = stall_w[1];

    p_zero_reg_rf_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rs1_i == '0) |-> (rs1_sel_o == SEL_RF));

    p_flush_all_rf_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (rs1_sel_o == SEL_RF && rs2_sel_o == SEL_RF));

    p_same_src_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rs1_i == rs2_i) |-> (rs1_sel_o == rs2_sel_o && rs1_stage_o == rs2_stage_o));

endmodule

// File: tb/sb_bypass_tracker_tb.sv
module sb_bypass_tracker_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       flush_i = 1'b0;
    logic       iss_valid_i = 1'b0;
    logic [1:0] iss_unit_i = '0;
    logic [4:0] iss_rd_i = '0;
    logic [4:0] rs1_i = '0;
    logic [4:0] rs2_i = '0;
    logic [1:0] rs1_sel_o, rs1_unit_o, rs2_sel_o, rs2_unit_o;
    logic [2:0] rs1_stage_o, rs2_stage_o;
    logic       rs1_stall_o, rs2_stall_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    sb_bypass_tracker dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush_i     (flush_i),
        .iss_valid_i (iss_valid_i),
        .iss_unit_i  (iss_unit_i),
        .iss_rd_i    (iss_rd_i),
        .rs1_i       (rs1_i),
        .rs2_i       (rs2_i),
        .rs1_sel_o   (rs1_sel_o),
        .rs1_unit_o  (rs1_unit_o),
        .rs1_stage_o (rs1_stage_o),
        .rs1_stall_o (rs1_stall_o),
        .rs2_sel_o   (rs2_sel_o),
        .rs2_unit_o  (rs2_unit_o),
        .rs2_stage_o (rs2_stage_o),
        .rs2_stall_o (rs2_stall_o)
    );

    typedef struct packed {
        logic       iv;
        logic [1:0] iu;
        logic [4:0] ird;
        logic       fl;
        logic [4:0] r1;
        logic [4:0] r2;
        logic [1:0] s1;
        logic [1:0] u1;
        logic [2:0] g1;
        logic [1:0] s2;
        logic [1:0] u2;
        logic [2:0] g2;
    } row_t;

    localparam int NROWS = 26;
    // Fields: issue, unit, rd, flush, rs1, rs2, exp sel/unit/stage for rs1 then rs2
    localparam row_t ROWS [NROWS] = '{
        '{0,0,0,0, 3,0, 0,0,0, 0,0,0},
        '{1,0,3,0, 3,3, 0,0,0, 0,0,0},
        '{0,0,0,0, 3,3, 1,0,0, 1,0,0},
        '{1,1,5,0, 3,0, 1,0,1, 0,0,0},
        '{1,2,7,0, 3,5, 0,0,0, 2,0,0},
        '{0,0,0,0, 5,7, 1,1,1, 2,0,0},
        '{0,0,0,0, 5,7, 1,1,2, 2,0,0},
        '{0,0,0,0, 5,7, 0,0,0, 2,0,0},
        '{0,0,0,0, 0,7, 0,0,0, 1,2,3},
        '{0,0,0,0, 0,7, 0,0,0, 1,2,4},
        '{1,2,9,0, 0,7, 0,0,0, 0,0,0},
        '{1,0,9,0, 9,0, 2,0,0, 0,0,0},
        '{0,0,0,0, 9,9, 1,0,0, 1,0,0},
        '{0,0,0,0, 9,0, 1,0,1, 0,0,0},
        '{0,0,0,0, 9,0, 0,0,0, 0,0,0},
        '{1,0,0,0, 0,0, 0,0,0, 0,0,0},
        '{1,2,4,0, 0,0, 0,0,0, 0,0,0},
        '{0,0,0,1, 4,0, 2,0,0, 0,0,0},
        '{0,0,0,0, 4,0, 0,0,0, 0,0,0},
        '{1,2,4,1, 4,4, 0,0,0, 0,0,0},
        '{0,0,0,0, 4,4, 0,0,0, 0,0,0},
        '{1,0,6,0, 6,0, 0,0,0, 0,0,0},
        '{1,0,6,0, 6,0, 1,0,0, 0,0,0},
        '{0,0,0,0, 6,6, 1,0,0, 1,0,0},
        '{0,0,0,0, 6,0, 1,0,1, 0,0,0},
        '{0,0,0,0, 6,0, 0,0,0, 0,0,0}
    };
    string row_req [NROWS] = '{
        "R1", "R3", "R9", "R4", "R5", "R5", "R5", "R5", "R6", "R6",
        "R6", "R7", "R7", "R7", "R7", "R2", "R2", "R6", "R8", "R8",
        "R8", "R3", "R7", "R7", "R4", "R4"
    };

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic chk_src1(input string req, input int s, input int u, input int g);
        chk(req, "rs1 sel", rs1_sel_o, s);
        chk(req, "rs1 unit", rs1_unit_o, u);
        chk(req, "rs1 stage", rs1_stage_o, g);
        chk(req, "rs1 stall", rs1_stall_o, (s == 2) ? 1 : 0);
    endtask

    task automatic chk_src2(input string req, input int s, input int u, input int g);
        chk(req, "rs2 sel", rs2_sel_o, s);
        chk(req, "rs2 unit", rs2_unit_o, u);
        chk(req, "rs2 stage", rs2_stage_o, g);
        chk(req, "rs2 stall", rs2_stall_o, (s == 2) ? 1 : 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        rs1_i = 5'd3;
        rs2_i = 5'd17;
        #4;
        chk_src1("R1", 0, 0, 0);
        chk_src2("R1", 0, 0, 0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NROWS; i++) begin
            @(negedge clk);
            iss_valid_i = ROWS[i].iv;
            iss_unit_i  = ROWS[i].iu;
            iss_rd_i    = ROWS[i].ird;
            flush_i     = ROWS[i].fl;
            rs1_i       = ROWS[i].r1;
            rs2_i       = ROWS[i].r2;
            #4;
            chk_src1(row_req[i], ROWS[i].s1, ROWS[i].u1, ROWS[i].g1);
            chk_src2(row_req[i], ROWS[i].s2, ROWS[i].u2, ROWS[i].g2);
        end

        // R1: reset in the middle of a multiply in flight
        @(negedge clk);
        iss_valid_i = 1'b1;
        iss_unit_i  = 2'd2;
        iss_rd_i    = 5'd2;
        flush_i     = 1'b0;
        @(negedge clk);
        iss_valid_i = 1'b0;
        rs1_i = 5'd2;
        rs2_i = 5'd2;
        #4;
        chk_src1("R6", 2, 0, 0);
        @(negedge clk);
        rst_n = 1'b0;
        #4;
        chk_src1("R1", 0, 0, 0);
        chk_src2("R1", 0, 0, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #4;
        chk_src1("R1", 0, 0, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule